// File: doc/BRIEF.md
# Hierarchy Walk Sequencer

This block walks a bounding volume hierarchy for a single ray. The hierarchy sits in word-addressed memory as fixed eight-word records. Each record holds two box corners, a signed count and a child field. After a start pulse the sequencer fetches record 0 at the given base pointer. It hands the record's corners to an outside box-test unit and acts on the hit or miss verdict. An interior record makes it descend to the left child and keep the right sibling on an internal stack. A leaf hands the first triangle address and the triangle count to a downstream triangle stage.

Records are read one at a time, only when they are needed. Reads use a request/valid handshake with variable latency. When the stack runs dry the sequencer raises a one-cycle done pulse and returns to idle. The floating-point ray/box and ray/triangle work stays outside the block. So do closest-hit ordering and culling.

Top module: `bvh_walker`

## Requirements
- R1: A `start` pulse in idle latches `base_addr`, clears `overflow` and begins with node ID 0, whose first read address is `base_addr`.
- R2: Node ID n occupies addresses `base + 8*n` to `base + 8*n + 7`. Its eight words are requested in ascending order, with at most one read outstanding. A new `mem_req` comes only after `mem_rvalid` has answered the previous one.
- R3: After the eight words arrive, exactly one single-cycle `box_req` is issued. `box_lo` carries words 0,1,2 and `box_hi` carries words 3,4,5, with the lowest-numbered word in the least significant 32 bits.
- R4: A box miss (`box_rsp_valid` with `box_hit`=0) causes no descent and no triangle handoff; traversal continues with a stack pop.
- R5: On a hit, a negative word 6 (sign bit set) marks an interior node. The left child ID, taken from the low bits of word 7, is fetched next, and left ID + 1 is pushed.
- R6: On a hit, a positive word 6 marks a leaf. `tri_valid` rises with `tri_addr` = word 7 and `tri_count` = word 6. Both hold steady until a cycle with `tri_ack` high, after which the stack is popped.
- R7: On a hit, a word 6 of zero is an empty leaf. It produces no handoff and is followed by a pop.
- R8: A pop with an empty stack raises `done` for exactly one cycle, and `busy` is low from that cycle on.
- R9: A push attempted while the stack already holds 32 entries sets `overflow`, raises `done` and ends the walk. `overflow` stays set until the next accepted start.
- R10: `start` while `busy` is ignored.
- R11: Deferred siblings are revisited in last-in, first-out order, so the walk is depth-first, left before right.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (honoured only in idle) |
| base_addr | input | 16 | Word address of node 0 |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| overflow | output | 1 | Sticky stack overflow flag |
| mem_req | output | 1 | Single-cycle read request |
| mem_addr | output | 16 | Read word address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| box_req | output | 1 | Single-cycle box-test request |
| box_lo | output | 96 | Minimum corner, words 0..2 |
| box_hi | output | 96 | Maximum corner, words 3..5 |
| box_rsp_valid | input | 1 | Box-test verdict valid |
| box_hit | input | 1 | Box-test verdict |
| tri_valid | output | 1 | Leaf handoff valid |
| tri_addr | output | 32 | First triangle address |
| tri_count | output | 32 | Number of triangles |
| tri_ack | input | 1 | Leaf handoff accepted |

## Verification
Some properties are checked by assertions on every cycle. These are the pulse width of `done` and `box_req`, and the stickiness of `overflow`. Another is the steadiness of the leaf handoff while it waits for acknowledge. The rest are that reads step by one word and stay one at a time, and that the stack is never pushed full or popped empty. Only the bench scenarios can show that the walk takes the right path. That covers miss pruning, zero-count leaves, last-in first-out sibling order and the exact overflow depth of 32. Those scenarios compare every read address, box request and handoff against a behavioural model of the traversal, with random latencies on all three handshakes.

// File: rtl/bvh_pkg.sv
package bvh_pkg;

    localparam int WORD_W     = 32;
    localparam int NODE_WORDS = 8;
    localparam int NODE_SHIFT = $clog2(NODE_WORDS);

    // Word positions inside a record (the layout is fixed by memory contents)
    localparam int WI_COUNT = 6;
    localparam int WI_CHILD = 7;

    typedef logic [NODE_WORDS-1:0][WORD_W-1:0] node_words_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_BOX,
        S_LEAF,
        S_POP
    } walk_state_t;

    typedef struct packed {
        logic [WORD_W-1:0]   lo;      // unused top bits: 3 words packed below
        logic [WORD_W-1:0]   count;
        logic [WORD_W-1:0]   child;
        logic                interior;
        logic                filled;  // leaf with at least one triangle
    } node_info_t;

    function automatic node_info_t decode_node(input node_words_t w);
        node_info_t n;
        n.lo       = w[0];
        n.count    = w[WI_COUNT];
        n.child    = w[WI_CHILD];
        n.interior = w[WI_COUNT][WORD_W-1];
        n.filled   = !w[WI_COUNT][WORD_W-1] && (|w[WI_COUNT]);
        return n;
    endfunction

endpackage

// File: rtl/bvh_stack.sv
module bvh_stack #(
    parameter int DEPTH = 32,
    parameter int W     = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_data,
    output logic [W-1:0] top,
    output logic         empty,
    output logic         full
);
    localparam int PW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  slots [DEPTH];
    logic [PW-1:0] sp;
    logic [PW-1:0] sp_m1;

    assign sp_m1 = sp - 1'b1;
    assign empty = (sp == '0);
    assign full  = (sp == PW'(DEPTH));
    assign top   = slots[sp_m1[IW-1:0]];

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            sp <= '0;
        end else if (push && !full) begin
            sp <= sp + 1'b1;
        end else if (pop && !empty) begin
            sp <= sp_m1;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !full) begin
            slots[sp[IW-1:0]] <= push_data;
        end
    end

    // R9: the sequencer must never push into a full stack
    p_push_room_r9: assert property (@(posedge clk) disable iff (rst)
        push |-> !full)
        else $error("push into full stack");

    // R8: the sequencer must never pop an empty stack
    p_pop_nonempty_r8: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty)
        else $error("pop from empty stack");

endmodule

// File: rtl/bvh_node_fetch.sv
module bvh_node_fetch
    import bvh_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic [AW-1:0]     node_addr,
    output logic              mem_req,
    output logic [AW-1:0]     mem_addr,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output node_words_t       words,
    output logic              fetch_done
);
    localparam int CW = NODE_SHIFT;
    localparam logic [CW-1:0] LAST = CW'(NODE_WORDS - 1);

    logic          active;
    logic [CW-1:0] idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            active     <= 1'b0;
            idx        <= '0;
            mem_req    <= 1'b0;
            mem_addr   <= '0;
            fetch_done <= 1'b0;
            words      <= '0;
        end else begin
            mem_req    <= 1'b0;
            fetch_done <= 1'b0;
            if (launch) begin
                active   <= 1'b1;
                idx      <= '0;
                mem_req  <= 1'b1;
                mem_addr <= node_addr;
            end else if (active && mem_rvalid) begin
                words[idx] <= mem_rdata;
                if (idx == LAST) begin
                    active     <= 1'b0;
                    fetch_done <= 1'b1;
                end else begin
                    idx      <= idx + 1'b1;
                    mem_req  <= 1'b1;
                    mem_addr <= mem_addr + 1'b1;
                end
            end
        end
    end

    // R2: each returned word that is not the last triggers the next address
    p_read_step_r2: assert property (@(posedge clk) disable iff (rst)
        (active && !launch && mem_rvalid && idx != LAST) |=>
            (mem_req && mem_addr == $past(mem_addr) + 1'b1))
        else $error("read sequence broken");

    // R2: a back-to-back request is only legal right after returned data
    p_one_outstanding_r2: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !launch) |=> (!mem_req || $past(mem_rvalid) || $past(launch)))
        else $error("second read while one outstanding");

endmodule

// File: rtl/bvh_walker.sv
module bvh_walker
    import bvh_pkg::*;
#(
    parameter int AW          = 16,
    parameter int IDW         = 16,
    parameter int STACK_DEPTH = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [AW-1:0]       base_addr,
    output logic                busy,
    output logic                done,
    output logic                overflow,
    output logic                mem_req,
    output logic [AW-1:0]       mem_addr,
    input  logic                mem_rvalid,
    input  logic [WORD_W-1:0]   mem_rdata,
    output logic                box_req,
    output logic [3*WORD_W-1:0] box_lo,
    output logic [3*WORD_W-1:0] box_hi,
    input  logic                box_rsp_valid,
    input  logic                box_hit,
    output logic                tri_valid,
    output logic [WORD_W-1:0]   tri_addr,
    output logic [WORD_W-1:0]   tri_count,
    input  logic                tri_ack
);
    walk_state_t    state;
    logic [IDW-1:0] cur_id;
    logic [AW-1:0]  base_q;
    logic [AW-1:0]  node_addr;
    logic           launch;
    logic           fetch_done;
    node_words_t    words;
    node_info_t     node;
    logic [IDW-1:0] left_id;

    logic           stk_clear, stk_push, stk_pop;
    logic           stk_empty, stk_full;
    logic [IDW-1:0] stk_top;

    assign node      = decode_node(words);
    assign left_id   = node.child[IDW-1:0];
    assign node_addr = base_q + (AW'(cur_id) << NODE_SHIFT);
    assign busy      = (state != S_IDLE);

    // Corners go out with the lowest-numbered word in the low bits
    genvar g;
    generate
        for (g = 0; g < 3; g++) begin : g_corner
            assign box_lo[g*WORD_W +: WORD_W] = words[g];
            assign box_hi[g*WORD_W +: WORD_W] = words[g+3];
        end
    endgenerate

    assign stk_clear = (state == S_IDLE) && start;
    assign stk_push  = (state == S_BOX) && box_rsp_valid && box_hit
                       && node.interior && !stk_full;
    assign stk_pop   = (state == S_POP) && !stk_empty;

    bvh_node_fetch #(.AW(AW)) u_fetch (
        .clk        (clk),
        .rst        (rst),
        .launch     (launch),
        .node_addr  (node_addr),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .words      (words),
        .fetch_done (fetch_done)
    );

    bvh_stack #(.DEPTH(STACK_DEPTH), .W(IDW)) u_stack (
        .clk       (clk),
        .rst       (rst),
        .clear     (stk_clear),
        .push      (stk_push),
        .pop       (stk_pop),
        .push_data (left_id + 1'b1),
        .top       (stk_top),
        .empty     (stk_empty),
        .full      (stk_full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            cur_id    <= '0;
            base_q    <= '0;
            launch    <= 1'b0;
            box_req   <= 1'b0;
            tri_valid <= 1'b0;
            tri_addr  <= '0;
            tri_count <= '0;
            done      <= 1'b0;
            overflow  <= 1'b0;
        end else begin
            launch  <= 1'b0;
            box_req <= 1'b0;
            done    <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        base_q   <= base_addr;
                        cur_id   <= '0;
                        overflow <= 1'b0;
                        launch   <= 1'b1;
                        state    <= S_FETCH;
                    end
                end
                S_FETCH: begin
                    if (fetch_done) begin
                        box_req <= 1'b1;
                        state   <= S_BOX;
                    end
                end
                S_BOX: begin
                    if (box_rsp_valid) begin
                        if (!box_hit) begin
                            state <= S_POP;
                        end else if (node.interior) begin
                            if (stk_full) begin
                                overflow <= 1'b1;
                                done     <= 1'b1;
                                state    <= S_IDLE;
                            end else begin
                                cur_id <= left_id;
                                launch <= 1'b1;
                                state  <= S_FETCH;
                            end
                        end else if (node.filled) begin
                            tri_valid <= 1'b1;
                            tri_addr  <= node.child;
                            tri_count <= node.count;
                            state     <= S_LEAF;
                        end else begin
                            state <= S_POP;
                        end
                    end
                end
                S_LEAF: begin
                    if (tri_ack) begin
                        tri_valid <= 1'b0;
                        state     <= S_POP;
                    end
                end
                S_POP: begin
                    if (stk_empty) begin
                        done  <= 1'b1;
                        state <= S_IDLE;
                    end else begin
                        cur_id <= stk_top;
                        launch <= 1'b1;
                        state  <= S_FETCH;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R8: done lasts a single cycle and coincides with leaving the walk
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done)
        else $error("done longer than one cycle");

    p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy)
        else $error("done while busy");

    // R9: overflow only clears on an accepted start
    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (overflow && !(start && !busy)) |=> overflow)
        else $error("overflow dropped");

    // R6: the leaf handoff holds until acknowledged
    p_tri_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (tri_valid && !tri_ack) |=>
            (tri_valid && $stable(tri_addr) && $stable(tri_count)))
        else $error("leaf handoff changed before ack");

    // R3: one box request per fetched record, one cycle wide
    p_box_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        box_req |=> !box_req)
        else $error("box request longer than one cycle");

    // R10: no memory traffic outside a walk
    p_mem_busy_r10: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy)
        else $error("read issued while idle");

endmodule

// File: tb/bvh_walker_bench.sv
module bvh_walker_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int AW = 16;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start = 1'b0;
    logic [AW-1:0]   base_addr = '0;
    logic            busy, done, overflow;
    logic            mem_req;
    logic [AW-1:0]   mem_addr;
    logic            mem_rvalid = 1'b0;
    logic [DW-1:0]   mem_rdata = '0;
    logic            box_req;
    logic [3*DW-1:0] box_lo, box_hi;
    logic            box_rsp_valid = 1'b0;
    logic            box_hit = 1'b0;
    logic            tri_valid;
    logic [DW-1:0]   tri_addr, tri_count;
    logic            tri_ack = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bvh_walker u_bvh_walker (
        .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
        .busy(busy), .done(done), .overflow(overflow),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .box_req(box_req), .box_lo(box_lo), .box_hi(box_hi),
        .box_rsp_valid(box_rsp_valid), .box_hit(box_hit),
        .tri_valid(tri_valid), .tri_addr(tri_addr), .tri_count(tri_count),
        .tri_ack(tri_ack)
    );

    logic [DW-1:0] mem [0:4095];
    int checks = 0;
    int failures = 0;

    int unsigned exp_rd[$];
    int unsigned exp_box[$];
    int unsigned exp_taddr[$];
    int unsigned exp_tcnt[$];
    bit          exp_ovf;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    task automatic put_node(input int unsigned base, input int unsigned id,
                            input bit hit, input int cnt, input int unsigned child);
        int unsigned a = base + id * 8;
        for (int k = 0; k < 6; k++) mem[a + k] = (id << 8) | (k << 4);
        mem[a] = mem[a] | 32'(hit);
        mem[a + 6] = cnt;
        mem[a + 7] = child;
    endtask

    // Behavioural traversal: builds the expected event streams
    task automatic model(input int unsigned base);
        int unsigned stk[$];
        int unsigned id = 0;
        exp_rd.delete(); exp_box.delete(); exp_taddr.delete(); exp_tcnt.delete();
        exp_ovf = 0;
        forever begin
            int unsigned a = base + id * 8;
            int cnt;
            bit hit;
            bit descend = 0;
            for (int k = 0; k < 8; k++) exp_rd.push_back(a + k);
            exp_box.push_back(a);
            hit = mem[a][0];
            cnt = mem[a + 6];
            if (hit) begin
                if (cnt < 0) begin
                    if (stk.size() == 32) begin
                        exp_ovf = 1;
                        break;
                    end
                    stk.push_back(mem[a + 7] + 1);
                    id = mem[a + 7];
                    descend = 1;
                end else if (cnt > 0) begin
                    exp_taddr.push_back(mem[a + 7]);
                    exp_tcnt.push_back(cnt);
                end
            end
            if (!descend) begin
                if (stk.size() == 0) break;
                id = stk.pop_back();
            end
        end
    endtask

    task automatic mem_agent();
        bit pend = 0;
        int lat = 0;
        int unsigned paddr = 0;
        forever begin
            @(negedge clk);
            mem_rvalid = 1'b0;
            if (!rst && mem_req) begin
                check(!pend, "R2", "request while read outstanding", 96'(pend), 0);
                check(exp_rd.size() > 0, "R2", "unexpected read", 96'(mem_addr), 0);
                if (exp_rd.size() > 0) begin
                    int unsigned e = exp_rd.pop_front();
                    check(mem_addr == AW'(e), "R1 R2 R5 R11", "read address",
                          96'(mem_addr), 96'(e));
                end
                pend = 1; paddr = mem_addr; lat = $urandom_range(0, 3);
            end
            if (pend) begin
                if (lat == 0) begin
                    mem_rvalid = 1'b1;
                    mem_rdata  = mem[paddr[11:0]];
                    pend = 0;
                end else lat--;
            end
        end
    endtask

    task automatic box_agent();
        bit pend = 0;
        bit vhit = 0;
        int lat = 0;
        forever begin
            @(negedge clk);
            box_rsp_valid = 1'b0;
            if (!rst && box_req) begin
                check(!pend, "R3", "box request while pending", 96'(pend), 0);
                check(exp_box.size() > 0, "R3", "unexpected box request", box_lo, 0);
                if (exp_box.size() > 0) begin
                    int unsigned a = exp_box.pop_front();
                    logic [95:0] elo = {mem[a + 2], mem[a + 1], mem[a]};
                    logic [95:0] ehi = {mem[a + 5], mem[a + 4], mem[a + 3]};
                    check(box_lo == elo, "R3", "box_lo", box_lo, elo);
                    check(box_hi == ehi, "R3", "box_hi", box_hi, ehi);
                    vhit = mem[a][0];
                end
                pend = 1; lat = $urandom_range(0, 4);
            end
            if (pend) begin
                if (lat == 0) begin
                    box_rsp_valid = 1'b1;
                    box_hit = vhit;
                    pend = 0;
                end else lat--;
            end
        end
    endtask

    task automatic tri_agent();
        bit in_xfer = 0;
        bit valid_q = 0, ack_q = 0;
        int unsigned saddr = 0, scnt = 0;
        int wait_n = 0;
        forever begin
            @(negedge clk);
            if (valid_q && ack_q) in_xfer = 0;
            if (!rst && tri_valid) begin
                if (!in_xfer) begin
                    check(exp_taddr.size() > 0, "R4 R6 R7", "unexpected leaf handoff",
                          96'(tri_addr), 0);
                    if (exp_taddr.size() > 0) begin
                        saddr = exp_taddr.pop_front();
                        scnt  = exp_tcnt.pop_front();
                    end
                    check(tri_addr == saddr, "R6", "tri_addr", 96'(tri_addr), 96'(saddr));
                    check(tri_count == scnt, "R6", "tri_count", 96'(tri_count), 96'(scnt));
                    in_xfer = 1;
                    wait_n = $urandom_range(0, 3);
                end else begin
                    check(tri_addr == saddr && tri_count == scnt, "R6",
                          "handoff held until ack", 96'(tri_addr), 96'(saddr));
                end
                tri_ack = (wait_n == 0);
                if (wait_n > 0) wait_n--;
            end else begin
                tri_ack = 1'b0;
            end
            valid_q = tri_valid;
            ack_q   = tri_ack;
        end
    endtask

    task automatic run_walk(input int unsigned base, input bit poke, input string tag);
        model(base);
        @(negedge clk);
        base_addr = AW'(base);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (20) @(negedge clk);
            check(busy, "R10", "walk still running before stray start", 96'(busy), 1);
            base_addr = 16'h0F00;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        check(!busy, "R8", {tag, " idle at done"}, 96'(busy), 0);
        check(overflow == exp_ovf, "R9", {tag, " overflow at done"},
              96'(overflow), 96'(exp_ovf));
        check(exp_rd.size() == 0 && exp_box.size() == 0, "R4 R10 R11",
              {tag, " all expected nodes visited"}, 96'(exp_rd.size()), 0);
        check(exp_taddr.size() == 0, "R6 R7", {tag, " all handoffs seen"},
              96'(exp_taddr.size()), 0);
        @(negedge clk);
        check(!done, "R8", {tag, " done lasts one cycle"}, 96'(done), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        // Walk A at 0x100: interior, miss, empty leaf and filled leaves
        put_node(32'h100, 0, 1, -1, 1);
        put_node(32'h100, 1, 1, -1, 3);
        put_node(32'h100, 2, 1, -1, 5);
        put_node(32'h100, 3, 1,  3, 32'h1000);
        put_node(32'h100, 4, 0,  2, 32'h2000);
        put_node(32'h100, 5, 1,  0, 32'h2500);
        put_node(32'h100, 6, 1,  1, 32'h3000);
        // Walk B at 0x400: root misses
        put_node(32'h400, 0, 0, -1, 1);
        // Walk C at 0x800: 41-deep left chain, always hit
        for (int i = 0; i < 41; i++) put_node(32'h800, i, 1, -1, i + 1);

        fork
            mem_agent();
            box_agent();
            tri_agent();
        join_none

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !overflow, "R8", "reset state flags",
              {busy, done, overflow}, 0);
        check(!mem_req && !box_req && !tri_valid, "R2", "reset state requests",
              {mem_req, box_req, tri_valid}, 0);

        run_walk(32'h100, 1'b0, "walk A");
        run_walk(32'h400, 1'b0, "walk B");
        run_walk(32'h800, 1'b0, "walk C");
        repeat (6) @(negedge clk);
        check(overflow, "R9", "overflow sticky while idle", 96'(overflow), 1);
        run_walk(32'h100, 1'b1, "walk A again");
        check(!overflow, "R1", "overflow cleared by start", 96'(overflow), 0);
        run_walk(32'h400, 1'b0, "walk B again");

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule